// File: doc/BRIEF.md
# Fast Restart and Power-Domain Reset Control Register

This block holds one 8-bit chipset configuration register, reached at index 0Ch through an index/data port pair, and the small amount of reset logic that the register steers. A restart may be requested in two ways: software writes a 1 to bit 0 of the fast-restart port, or the keyboard controller reports link code 101. Each accepted request makes a state machine arm, wait for the processor's bus-hold acknowledge to reach the configured level, and then drive a fixed-length CPU reset pulse. Any request that arrives while a pulse is pending or active joins that pulse.

The same register sets a one-way lock that blocks access to the protected area of CMOS RAM, and it enables the IRQ12 output for the mouse interrupt. Its top bit, the core-keep bit, sits in a battery-backed domain. While that bit is set, the core registers survive a loss of main power. The battery reset can clear the bit only while main power is absent. So both reset inputs must be low together to force a full core reset.

The restart state machine has three states. ST_IDLE waits for a request. ST_ARMED holds a pending request until the hold acknowledge matches the configured mode. ST_PULSE drives the CPU reset for PULSE_LEN clocks. The transitions are as follows. ST_IDLE goes to ST_ARMED on an accepted request. ST_ARMED goes to ST_PULSE on a cycle where hold matches. ST_PULSE goes to ST_IDLE once the last pulse clock has passed. A core reset returns the machine from any state to ST_IDLE.

Top module: `p92_rst_ctl`

## Requirements
- R1: A core reset happens while `pwr_good` is low and the core-keep bit (bit 7) is 0, or while `pwr_good` and `bat_rst_n` are both low. During it, `core_rst` is 1. Afterwards bits 5..0 read 0, `pw_block` is 0, `irq12_en` is 0 and `cpu_rst` is 0.
- R2: The register sits at index 0Ch. A byte is written to `bus_wdata` with `idx_wr`, or with `dat_wr` for data. With that index selected, `bus_rdata` returns the register and bits 2 and 6 always read 0. With any other index selected, data writes leave the register unchanged and `bus_rdata` is 00h.
- R3: When bit 0 is 0, a `p92_wr` strobe with `p92_bit0`=1 requests a restart. When bit 0 is 1, or when `p92_bit0`=0, the strobe produces no `cpu_rst` pulse.
- R4: A `kbc_code_vld` strobe with `kbc_code`=3'b101 requests a restart when bit 4 is 0. It produces no pulse when bit 4 is 1, and no other code value produces a pulse.
- R5: When bit 3 is 0, a pending restart starts its pulse only on a cycle where `hlda` is 0. When bit 3 is 1, it starts only on a cycle where `hlda` is 1. Until then the request stays pending.
- R6: Each pulse on `cpu_rst` lasts exactly PULSE_LEN (16) clocks. Requests that arrive while a restart is pending or pulsing are merged and add no pulse.
- R7: A data write with bit 1 = 1 sets `pw_block` on the next clock. Later writes of bit 1 = 0 clear the read-back of bit 1 but leave `pw_block` at 1. Only a core reset clears it.
- R8: `irq12_en` equals bit 5 of the register.
- R9: While bit 7 is 1, dropping `pwr_good` with `bat_rst_n` high keeps all register bits and leaves `core_rst` at 0. Bit 7 is never cleared by `pwr_good` alone.
- R10: While `pwr_good` is high, `bat_rst_n` low has no effect. When both are low, bit 7 is cleared and a core reset takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Main power good, high when powered |
| bat_rst_n | input | 1 | Battery-domain reset, active low |
| idx_wr | input | 1 | Load `bus_wdata` into the index latch |
| dat_wr | input | 1 | Write `bus_wdata` to the selected register |
| bus_wdata | input | 8 | Write data for index and data cycles |
| bus_rdata | output | 8 | Read data of the selected register, 00h when not selected |
| p92_wr | input | 1 | Fast-restart port write strobe |
| p92_bit0 | input | 1 | Bit 0 of the fast-restart port write |
| kbc_code_vld | input | 1 | Keyboard-controller link code strobe |
| kbc_code | input | 3 | Keyboard-controller link code |
| hlda | input | 1 | Processor bus-hold acknowledge |
| cpu_rst | output | 1 | CPU reset pulse |
| core_rst | output | 1 | Core register reset in effect |
| pw_block | output | 1 | Block access to the protected CMOS RAM area |
| irq12_en | output | 1 | Enable driving IRQ12 from the mouse interrupt |

## Verification
On every cycle, the assertions check four things: the length of each CPU reset pulse, that a pulse starts only after a cycle with a matching hold acknowledge, that the lock never drops outside a core reset, and that core reset stays off while main power is good. They also check that the reserved bits read zero and that the machine comes out of core reset idle with the lock off. The bench scenarios show the remaining behaviour: merging of overlapping requests, the disable bits for the port and link-code restarts, preservation of the register across a power loss with the core-keep bit set, and the full clear when both reset inputs fall together.

// File: rtl/p92_rst_pkg.sv
package p92_rst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PULSE = 2'd2
    } rst_state_t;

    // Field positions inside the configuration byte
    localparam int unsigned FB_FAST_DIS  = 0;
    localparam int unsigned FB_PW_EN     = 1;
    localparam int unsigned FB_HOLD_MODE = 3;
    localparam int unsigned FB_LINK_DIS  = 4;
    localparam int unsigned FB_IRQ_EN    = 5;
    localparam int unsigned FB_KEEP      = 7;

    localparam logic [2:0] LINK_RESTART_CODE = 3'b101;

endpackage

// File: rtl/p92_index_port.sv
module p92_index_port #(
    parameter int unsigned  W         = 8,
    parameter logic [W-1:0] REG_INDEX = 8'h0C
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         idx_wr,
    input  logic         dat_wr,
    input  logic [W-1:0] wdata,
    output logic         sel,
    output logic         wr_hit
);

    logic [W-1:0] index_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
        end else if (idx_wr) begin
            index_q <= wdata;
        end
    end

    always_comb begin
        sel    = (index_q == REG_INDEX);
        wr_hit = sel && dat_wr && !rst;
    end

endmodule

// File: rtl/p92_cfg_reg.sv
module p92_cfg_reg
    import p92_rst_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         core_rst,
    input  logic         bat_clr,
    input  logic         wr_hit,
    input  logic [W-1:0] wdata,
    output logic         fast_dis,
    output logic         pw_en,
    output logic         hold_mode,
    output logic         link_dis,
    output logic         irq_en,
    output logic         keep,
    output logic         lock,
    output logic [W-1:0] rd_val
);

    // Core-domain fields
    always_ff @(posedge clk) begin
        if (core_rst) begin
            fast_dis  <= 1'b0;
            pw_en     <= 1'b0;
            hold_mode <= 1'b0;
            link_dis  <= 1'b0;
            irq_en    <= 1'b0;
        end else if (wr_hit) begin
            fast_dis  <= wdata[FB_FAST_DIS];
            pw_en     <= wdata[FB_PW_EN];
            hold_mode <= wdata[FB_HOLD_MODE];
            link_dis  <= wdata[FB_LINK_DIS];
            irq_en    <= wdata[FB_IRQ_EN];
        end
    end

    // One-way lock: only core reset releases it
    always_ff @(posedge clk) begin
        if (core_rst) begin
            lock <= 1'b0;
        end else if (wr_hit && wdata[FB_PW_EN]) begin
            lock <= 1'b1;
        end
    end

    // Battery-domain bit
    always_ff @(posedge clk) begin
        if (bat_clr) begin
            keep <= 1'b0;
        end else if (wr_hit) begin
            keep <= wdata[FB_KEEP];
        end
    end

    always_comb begin
        rd_val               = '0;
        rd_val[FB_FAST_DIS]  = fast_dis;
        rd_val[FB_PW_EN]     = pw_en;
        rd_val[FB_HOLD_MODE] = hold_mode;
        rd_val[FB_LINK_DIS]  = link_dis;
        rd_val[FB_IRQ_EN]    = irq_en;
        rd_val[FB_KEEP]      = keep;
    end

endmodule

// File: rtl/p92_restart_fsm.sv
module p92_restart_fsm
    import p92_rst_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic hold_ok,
    output logic cpu_rst
);

    localparam int unsigned CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_LEN - 1);

    rst_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             pulse_done;

    assign pulse_done = (cnt_q == CNT_LAST);

    // State register and pulse counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PULSE) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // Transitions; requests outside ST_IDLE merge into the current one
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req)        state_d = ST_ARMED;
            ST_ARMED: if (hold_ok)    state_d = ST_PULSE;
            ST_PULSE: if (pulse_done) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_rst = 1'b0;
        unique case (state_q)
            ST_IDLE:  cpu_rst = 1'b0;
            ST_ARMED: cpu_rst = 1'b0;
            ST_PULSE: cpu_rst = 1'b1;
            default:  cpu_rst = 1'b0;
        endcase
    end

endmodule

// File: rtl/p92_rst_ctl.sv
module p92_rst_ctl
    import p92_rst_pkg::*;
#(
    parameter int unsigned  W         = 8,
    parameter logic [W-1:0] REG_INDEX = 8'h0C,
    parameter int unsigned  PULSE_LEN = 16
) (
    input  logic         clk,
    input  logic         pwr_good,
    input  logic         bat_rst_n,
    input  logic         idx_wr,
    input  logic         dat_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         p92_wr,
    input  logic         p92_bit0,
    input  logic         kbc_code_vld,
    input  logic [2:0]   kbc_code,
    input  logic         hlda,
    output logic         cpu_rst,
    output logic         core_rst,
    output logic         pw_block,
    output logic         irq12_en
);

    logic         bat_clr;
    logic         sel;
    logic         wr_hit;
    logic         fast_dis;
    logic         pw_en;
    logic         hold_mode;
    logic         link_dis;
    logic         irq_en;
    logic         keep;
    logic         lock;
    logic [W-1:0] rd_val;
    logic         req;
    logic         hold_ok;

    // Battery reset is masked while main power is good
    assign bat_clr  = !bat_rst_n && !pwr_good;
    assign core_rst = !pwr_good && (!keep || bat_clr);

    p92_index_port #(
        .W         (W),
        .REG_INDEX (REG_INDEX)
    ) idx_i (
        .clk    (clk),
        .rst    (core_rst),
        .idx_wr (idx_wr),
        .dat_wr (dat_wr),
        .wdata  (bus_wdata),
        .sel    (sel),
        .wr_hit (wr_hit)
    );

    p92_cfg_reg #(
        .W (W)
    ) cfg_i (
        .clk       (clk),
        .core_rst  (core_rst),
        .bat_clr   (bat_clr),
        .wr_hit    (wr_hit),
        .wdata     (bus_wdata),
        .fast_dis  (fast_dis),
        .pw_en     (pw_en),
        .hold_mode (hold_mode),
        .link_dis  (link_dis),
        .irq_en    (irq_en),
        .keep      (keep),
        .lock      (lock),
        .rd_val    (rd_val)
    );

    always_comb begin
        req = (p92_wr && p92_bit0 && !fast_dis)
            || (kbc_code_vld && (kbc_code == LINK_RESTART_CODE) && !link_dis);
        hold_ok = hold_mode ? hlda : !hlda;
    end

    p92_restart_fsm #(
        .PULSE_LEN (PULSE_LEN)
    ) fsm_i (
        .clk     (clk),
        .rst     (core_rst),
        .req     (req),
        .hold_ok (hold_ok),
        .cpu_rst (cpu_rst)
    );

    assign bus_rdata = sel ? rd_val : '0;
    assign pw_block  = lock;
    assign irq12_en  = irq_en;

endmodule

// File: rtl/p92_rst_chk.sv
module p92_rst_chk #(
    parameter int unsigned W         = 8,
    parameter int unsigned PULSE_LEN = 16
) (
    input logic         clk,
    input logic         pwr_good,
    input logic         bat_clr,
    input logic         core_rst,
    input logic         cpu_rst,
    input logic         pw_block,
    input logic         hlda,
    input logic         hold_mode,
    input logic [W-1:0] bus_rdata
);

    localparam int unsigned RC_W = $clog2(PULSE_LEN + 1) + 1;

    logic [RC_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (core_rst || !cpu_rst) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (core_rst)
        $fell(cpu_rst) |-> (run_cnt == RC_W'(PULSE_LEN)));

    // R5
    hold_gate_chk: assert property (@(posedge clk) disable iff (core_rst)
        $rose(cpu_rst) |-> ($past(hlda) == $past(hold_mode)));

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (core_rst)
        pw_block |=> pw_block);

    // R10
    bat_masked_chk: assert property (@(posedge clk) disable iff (bat_clr)
        pwr_good |-> !core_rst);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (bat_clr)
        core_rst |=> (!cpu_rst && !pw_block));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (core_rst)
        (bus_rdata[2] == 1'b0) && (bus_rdata[6] == 1'b0));

endmodule

bind p92_rst_ctl p92_rst_chk #(
    .W         (W),
    .PULSE_LEN (PULSE_LEN)
) chk_i (
    .clk       (clk),
    .pwr_good  (pwr_good),
    .bat_clr   (bat_clr),
    .core_rst  (core_rst),
    .cpu_rst   (cpu_rst),
    .pw_block  (pw_block),
    .hlda      (hlda),
    .hold_mode (hold_mode),
    .bus_rdata (bus_rdata)
);

// File: tb/p92_rst_ctl_tb_top.sv
module p92_rst_ctl_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  PLEN       = 16;

    logic       clk = 1'b0;
    logic       pwr_good, bat_rst_n, idx_wr, dat_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       p92_wr, p92_bit0, kbc_code_vld;
    logic [2:0] kbc_code;
    logic       hlda;
    logic       cpu_rst, core_rst, pw_block, irq12_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    p92_rst_ctl dut_i (
        .clk          (clk),
        .pwr_good     (pwr_good),
        .bat_rst_n    (bat_rst_n),
        .idx_wr       (idx_wr),
        .dat_wr       (dat_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .p92_wr       (p92_wr),
        .p92_bit0     (p92_bit0),
        .kbc_code_vld (kbc_code_vld),
        .kbc_code     (kbc_code),
        .hlda         (hlda),
        .cpu_rst      (cpu_rst),
        .core_rst     (core_rst),
        .pw_block     (pw_block),
        .irq12_en     (irq12_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_index(input logic [7:0] v);
        @(negedge clk);
        idx_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        idx_wr = 1'b0;
    endtask

    task automatic write_data(input logic [7:0] v);
        @(negedge clk);
        dat_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic p92_strobe(input logic b0);
        @(negedge clk);
        p92_wr = 1'b1; p92_bit0 = b0;
        @(negedge clk);
        p92_wr = 1'b0;
    endtask

    task automatic kbc_strobe(input logic [2:0] c);
        @(negedge clk);
        kbc_code_vld = 1'b1; kbc_code = c;
        @(negedge clk);
        kbc_code_vld = 1'b0;
    endtask

    // Observe cpu_rst for n cycles; optionally inject a port strobe at cycle inj
    task automatic window(input int n, input int inj, output int hi, output int rises);
        logic prev;
        hi = 0; rises = 0;
        prev = cpu_rst;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            p92_wr = (i == inj);
            p92_bit0 = 1'b1;
            if (cpu_rst) hi++;
            if (cpu_rst && !prev) rises++;
            prev = cpu_rst;
        end
        p92_wr = 1'b0;
    endtask

    task automatic power_cycle(input logic bat_too);
        @(negedge clk);
        pwr_good = 1'b0; bat_rst_n = !bat_too;
        repeat (3) @(negedge clk);
        n_tests++;
        if (core_rst !== (bat_too ? 1'b1 : !bus_rdata[7])) begin
            n_fail++;
            $display("FAIL R1/R9: core_rst actual %0b", core_rst);
        end
        bat_rst_n = 1'b1; pwr_good = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        check("R1 core_rst during reset", core_rst, 1);
        @(negedge clk);
        bat_rst_n = 1'b1; pwr_good = 1'b1;
        set_index(8'h0C);
        check("R1 reg after reset", bus_rdata, 8'h00);
        check("R1 cpu_rst after reset", cpu_rst, 0);
        check("R1 pw_block after reset", pw_block, 0);
        check("R1 irq12_en after reset", irq12_en, 0);
        check("R1 core_rst released", core_rst, 0);
    endtask

    task automatic t_regs;
        write_data(8'hFF & 8'h79);
        check("R2 reserved read zero", bus_rdata, 8'h39);
        check("R8 irq12 on", irq12_en, 1);
        write_data(8'h00);
        check("R8 irq12 off", irq12_en, 0);
        write_data(8'h30);
        set_index(8'h0D);
        check("R2 other index reads zero", bus_rdata, 8'h00);
        write_data(8'h00);
        check("R2 other index write ignored irq", irq12_en, 1);
        set_index(8'h0C);
        check("R2 value kept", bus_rdata, 8'h30);
        write_data(8'h00);
    endtask

    task automatic t_port_restart;
        int hi, r;
        p92_strobe(1'b1);
        window(40, -1, hi, r);
        check("R3 port restart high cycles", hi, PLEN);
        check("R6 single pulse", r, 1);
        p92_strobe(1'b0);
        window(30, -1, hi, r);
        check("R3 bit0=0 strobe ignored", hi, 0);
        write_data(8'h01);
        p92_strobe(1'b1);
        window(30, -1, hi, r);
        check("R3 disabled port restart", hi, 0);
        write_data(8'h00);
    endtask

    task automatic t_link_code;
        int hi, r;
        kbc_strobe(3'b101);
        window(40, -1, hi, r);
        check("R4 link code restart", hi, PLEN);
        kbc_strobe(3'b100);
        window(30, -1, hi, r);
        check("R4 other code ignored", hi, 0);
        write_data(8'h10);
        kbc_strobe(3'b101);
        window(30, -1, hi, r);
        check("R4 disabled link restart", hi, 0);
        write_data(8'h00);
    endtask

    task automatic t_merge;
        int hi, r;
        p92_strobe(1'b1);
        window(40, 6, hi, r);
        check("R6 merged high cycles", hi, PLEN);
        check("R6 merged pulse count", r, 1);
    endtask

    task automatic t_hold;
        int hi, r;
        hlda = 1'b1;
        p92_strobe(1'b1);
        window(30, -1, hi, r);
        check("R5 mode0 held while hlda=1", hi, 0);
        hlda = 1'b0;
        window(30, -1, hi, r);
        check("R5 mode0 issues after hlda=0", hi, PLEN);
        write_data(8'h08);
        p92_strobe(1'b1);
        window(30, -1, hi, r);
        check("R5 mode1 held while hlda=0", hi, 0);
        hlda = 1'b1;
        window(30, -1, hi, r);
        check("R5 mode1 issues after hlda=1", hi, PLEN);
        hlda = 1'b0;
        write_data(8'h00);
    endtask

    task automatic t_lock;
        write_data(8'h02);
        check("R7 lock set", pw_block, 1);
        write_data(8'h00);
        check("R7 lock stays", pw_block, 1);
        check("R7 bit1 readback cleared", bus_rdata, 8'h00);
        power_cycle(1'b0);
        set_index(8'h0C);
        check("R7 lock cleared by core reset", pw_block, 0);
    endtask

    task automatic t_keep;
        write_data(8'hB0);
        power_cycle(1'b0);
        set_index(8'h0C);
        check("R9 kept across power loss", bus_rdata, 8'hB0);
        @(negedge clk);
        bat_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 battery reset masked core_rst", core_rst, 0);
        bat_rst_n = 1'b1;
        @(negedge clk);
        check("R10 battery reset masked value", bus_rdata, 8'hB0);
        power_cycle(1'b1);
        set_index(8'h0C);
        check("R10 both low clears all", bus_rdata, 8'h00);
    endtask

    initial begin
        pwr_good = 1'b0; bat_rst_n = 1'b0;
        idx_wr = 1'b0; dat_wr = 1'b0; bus_wdata = '0;
        p92_wr = 1'b0; p92_bit0 = 1'b0;
        kbc_code_vld = 1'b0; kbc_code = '0; hlda = 1'b0;
        repeat (4) @(negedge clk);
        t_reset_state();
        t_regs();
        t_port_restart();
        t_link_code();
        t_merge();
        t_hold();
        t_lock();
        t_keep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule